// File: doc/BRIEF.md
# Single-Pixel Comparator Sample Packer

This controller repeatedly samples the one-bit comparator decision of a single sensor pixel and packs the results into bytes for an on-chip RAM. A one-cycle start request (from an already debounced push button) launches a run. For every sample the block first waits a programmable settling time, then raises a one-cycle data-valid strobe while it takes the comparator bit. Eight consecutive bits form one word. Each completed word leaves the block on a RAM write port, and the word address advances by one per word.

A run always holds 256 samples, so it fills words 0 through 31. After the last sample the controller parks in a hold state. There it drives three sensor reset lines: the column/row-select reset, the photodiode reset and the voltage reset. It stays there until the next start request. For bench-top tests driven by hand, the settling parameter can be raised to millions of cycles so that a person can change the comparator input between samples.

Top module: `pixel_sample_packer`

## Requirements
- R1: A synchronous active-high reset puts the block in idle: no strobe, no write, all three reset outputs low, write address 0 and write data 0. The block then stays quiet until a start request.
- R2: A start request accepted in idle or hold is followed by exactly SETTLE_CYCLES (default 3) settling cycles. The first data-valid strobe is high in the cycle SETTLE_CYCLES+1 cycles after the cycle in which start was high.
- R3: The data-valid strobe is one cycle wide. Within a run, consecutive strobes are exactly SETTLE_CYCLES+1 cycles apart.
- R4: The comparator input is sampled at the clock edge that ends a strobe cycle. Sample k of a run (counting from 0) is stored in bit (k mod 8) of word k/8, so the first sample of a word lands in bit 0.
- R5: The write enable is a single-cycle pulse in the cycle after the eighth sample of a word. It carries that completed word, and its address counts 0, 1, 2, ... through the run.
- R6: A run takes exactly 256 samples and writes 32 words. From the cycle after the last sample, the three reset outputs are high together and no further strobes occur.
- R7: The hold state and its reset outputs persist for as long as no start request arrives. A start in hold drops the resets and begins a fresh run, whose first write goes to address 0.
- R8: A start request that arrives while a run is in progress is ignored. The sampling cadence, the sample count and the address sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle start request (debounced button) |
| comp_i | input | 1 | Comparator decision of the pixel |
| sample_valid_o | output | 1 | Data-valid strobe, high in the sampling cycle |
| sel_rst_o | output | 1 | Column/row-select reset, high in hold |
| pd_rst_o | output | 1 | Photodiode reset, high in hold |
| v_rst_o | output | 1 | Voltage reset, high in hold |
| mem_we_o | output | 1 | RAM write enable, one cycle per word |
| mem_addr_o | output | ADDR_W (5) | RAM word address |
| mem_wdata_o | output | WORD_BITS (8) | Packed word of comparator samples |

## Verification
A settle counter that is off by one moves every strobe. The error shows as a wrong spacing at the very first strobe after start, within SETTLE_CYCLES+1 cycles. A bad bit index or word counter corrupts the byte or address of the first write, eight samples into a run. A miscounted run length only appears at the end of a run: the hold resets rise early or late, or the number of writes is not 32. A controller that restarts on a mid-run start breaks the strobe spacing in the cycles that follow.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

  // Controller phases; HOLD is the post-run state that drives the sensor resets.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETTLE  = 2'd1,
    PH_CAPTURE = 2'd2,
    PH_HOLD    = 2'd3
  } phase_e;

  // A start is honoured only when no run is in flight.
  function automatic logic can_accept(input phase_e ph);
    return (ph == PH_IDLE) || (ph == PH_HOLD);
  endfunction

endpackage

// File: rtl/pix_settle_timer.sv
module pix_settle_timer #(
  parameter int SETTLE_CYCLES = 3,
  localparam int CW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic done
);

  logic [CW-1:0] cnt_q;

  // The count restarts from zero every time arm rises.
  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = arm && (cnt_q == CW'(SETTLE_CYCLES - 1));

endmodule

// File: rtl/pix_run_sequencer.sv
module pix_run_sequencer
  import pix_pack_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   settle_done,
  input  logic   run_last,
  output phase_e phase_q,
  output logic   accept_evt
);

  phase_e phase_d;

  assign accept_evt = start_i && can_accept(phase_q);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE, PH_HOLD: if (accept_evt)  phase_d = PH_SETTLE;
      PH_SETTLE:        if (settle_done) phase_d = PH_CAPTURE;
      PH_CAPTURE:       phase_d = run_last ? PH_HOLD : PH_SETTLE;
      default:          phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/pix_bit_packer.sv
module pix_bit_packer #(
  parameter int WORD_BITS   = 8,
  parameter int NUM_SAMPLES = 256,
  localparam int IW     = $clog2(WORD_BITS),
  localparam int SW     = $clog2(NUM_SAMPLES),
  localparam int ADDR_W = SW - IW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 capture,
  input  logic                 bit_i,
  output logic                 last_o,
  output logic                 word_end_o,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [WORD_BITS-1:0] data_o
);

  logic [SW-1:0]        cnt_q;
  logic [WORD_BITS-1:0] pack_q;
  logic [WORD_BITS-1:0] pack_next;
  logic [IW-1:0]        idx;
  logic [ADDR_W-1:0]    word_idx;

  // Write one bit into a word at a given position.
  function automatic logic [WORD_BITS-1:0] place_bit(
    input logic [WORD_BITS-1:0] w,
    input logic [IW-1:0]        pos,
    input logic                 b
  );
    logic [WORD_BITS-1:0] r;
    r      = w;
    r[pos] = b;
    return r;
  endfunction

  assign idx        = cnt_q[IW-1:0];
  assign word_idx   = cnt_q[SW-1:IW];
  assign pack_next  = place_bit(pack_q, idx, bit_i);
  assign word_end_o = (idx == IW'(WORD_BITS - 1));
  assign last_o     = (cnt_q == SW'(NUM_SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pack_q <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (clear) begin
        cnt_q  <= '0;
        pack_q <= '0;
      end else if (capture) begin
        cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        if (word_end_o) begin
          we_o   <= 1'b1;
          addr_o <= word_idx;
          data_o <= pack_next;
          pack_q <= '0;
        end else begin
          pack_q <= pack_next;
        end
      end
    end
  end

endmodule

// File: rtl/pixel_sample_packer.sv
module pixel_sample_packer
  import pix_pack_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3,
  parameter int WORD_BITS     = 8,
  parameter int NUM_SAMPLES   = 256,
  localparam int ADDR_W = $clog2(NUM_SAMPLES) - $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 comp_i,
  output logic                 sample_valid_o,
  output logic                 sel_rst_o,
  output logic                 pd_rst_o,
  output logic                 v_rst_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [WORD_BITS-1:0] mem_wdata_o
);

  phase_e phase_q;
  logic   accept_evt;
  logic   settle_done;
  logic   capture_evt;
  logic   run_last;
  logic   word_end_evt;
  logic   run_end_evt;

  assign capture_evt = (phase_q == PH_CAPTURE);
  assign run_end_evt = capture_evt && run_last;

  pix_run_sequencer u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .settle_done (settle_done),
    .run_last    (run_last),
    .phase_q     (phase_q),
    .accept_evt  (accept_evt)
  );

  pix_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .arm  (phase_q == PH_SETTLE),
    .done (settle_done)
  );

  pix_bit_packer #(.WORD_BITS(WORD_BITS), .NUM_SAMPLES(NUM_SAMPLES)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept_evt),
    .capture    (capture_evt),
    .bit_i      (comp_i),
    .last_o     (run_last),
    .word_end_o (word_end_evt),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .data_o     (mem_wdata_o)
  );

  assign sample_valid_o = capture_evt;
  assign sel_rst_o      = (phase_q == PH_HOLD);
  assign pd_rst_o       = (phase_q == PH_HOLD);
  assign v_rst_o        = (phase_q == PH_HOLD);

endmodule

// File: rtl/pix_packer_checker.sv
module pix_packer_checker
  import pix_pack_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3,
  parameter int ADDR_W        = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              sample_valid_o,
  input logic              sel_rst_o,
  input logic              pd_rst_o,
  input logic              v_rst_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input phase_e            phase_q,
  input logic              accept_evt,
  input logic              run_end_evt
);

  int   gap_q;
  int   wr_q;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      gap_q <= 0;
      wr_q  <= 0;
    end else begin
      gap_q <= (phase_q == PH_SETTLE) ? gap_q + 1 : 0;
      if (accept_evt)    wr_q <= 0;
      else if (mem_we_o) wr_q <= wr_q + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_idle_r1: assert (!mem_we_o && !sample_valid_o && !sel_rst_o && mem_addr_o == '0)
        else $error("reset did not leave the block idle");
    end
  end

  p_settle_len_r2: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> gap_q == SETTLE_CYCLES);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |=> !sample_valid_o);

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o);

  p_write_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(sample_valid_o));

  p_addr_seq_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_addr_o == ADDR_W'(wr_q));

  p_resets_agree_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_rst_o == pd_rst_o) && (pd_rst_o == v_rst_o));

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    sel_rst_o |-> !sample_valid_o);

  p_end_to_hold_r6: assert property (@(posedge clk) disable iff (rst)
    run_end_evt |=> sel_rst_o);

  p_hold_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    sel_rst_o && !start_i |=> sel_rst_o);

endmodule

bind pixel_sample_packer pix_packer_checker #(
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .sample_valid_o (sample_valid_o),
  .sel_rst_o      (sel_rst_o),
  .pd_rst_o       (pd_rst_o),
  .v_rst_o        (v_rst_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .phase_q        (phase_q),
  .accept_evt     (accept_evt),
  .run_end_evt    (run_end_evt)
);

// File: tb/pixel_sample_packer_test.sv
module pixel_sample_packer_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int WB         = 8;
  localparam int NS         = 256;
  localparam int NW         = NS / WB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       comp_i = 1'b0;
  logic       sample_valid_o, sel_rst_o, pd_rst_o, v_rst_o, mem_we_o;
  logic [4:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pixel_sample_packer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .comp_i(comp_i),
    .sample_valid_o(sample_valid_o), .sel_rst_o(sel_rst_o), .pd_rst_o(pd_rst_o),
    .v_rst_o(v_rst_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int run_id = 0;
  int k = 0;
  int strobes = 0;
  int writes = 0;
  int last_strobe = 0;
  int start_cyc = 0;
  logic [7:0]  acc = '0;
  logic [12:0] exp_q[$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Comparator stimulus per run.
  function automatic logic pat(input int r, input int i);
    int v;
    v = (i * 13 + r * 7) ^ (i >> 3);
    return v[2];
  endfunction

  // One cycle: advance to the falling edge, compare writes, drive the next sample.
  task automatic step();
    logic [12:0] e;
    logic        b;
    @(negedge clk);
    cyc++;
    if (rst) return;
    if (mem_we_o) begin
      writes++;
      if (exp_q.size() == 0) begin
        check("R5 write without expected word", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check("R5 write address", int'(mem_addr_o), int'(e[12:8]));
        check("R4 packed word", int'(mem_wdata_o), int'(e[7:0]));
      end
    end
    if (sample_valid_o) begin
      if (strobes == 0) check("R2 first strobe delay", cyc - start_cyc, SETTLE + 1);
      else              check("R3 strobe spacing", cyc - last_strobe, SETTLE + 1);
      last_strobe = cyc;
      strobes++;
      b = pat(run_id, k);
      comp_i = b;
      acc[k % WB] = b;
      if (k % WB == WB - 1) begin
        exp_q.push_back({5'(k / WB), acc});
        acc = '0;
      end
      k++;
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic begin_run(input int id);
    run_id = id; k = 0; strobes = 0; writes = 0; acc = '0;
    start_cyc = cyc;
    pulse_start();
  endtask

  task automatic full_run(input int id, input bit mid_start);
    int guard;
    bit poked;
    guard = 0;
    poked = 0;
    begin_run(id);
    while (strobes < NS && guard < 4000) begin
      if (mid_start && !poked && strobes == 100) begin
        poked = 1;
        pulse_start();   // R8: ignored while running
      end else begin
        step();
      end
      guard++;
    end
    repeat (3) step();
    check("R6 samples per run", strobes, NS);
    check("R6 words per run", writes, NW);
    check("R5 no pending words", exp_q.size(), 0);
    check("R6 select reset in hold", int'(sel_rst_o), 1);
    check("R6 photodiode reset in hold", int'(pd_rst_o), 1);
    check("R6 voltage reset in hold", int'(v_rst_o), 1);
    repeat (20) step();
    check("R7 hold persists", int'(sel_rst_o && pd_rst_o && v_rst_o), 1);
    check("R7 no strobes in hold", strobes, NS);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 idle strobe", int'(sample_valid_o), 0);
        check("R1 idle resets", int'(sel_rst_o | pd_rst_o | v_rst_o), 0);
        check("R1 idle write", int'(mem_we_o), 0);
        check("R1 idle address", int'(mem_addr_o), 0);
        check("R1 idle data", int'(mem_wdata_o), 0);
        repeat (10) step();
        check("R1 no strobe without start", strobes, 0);

        full_run(0, 1'b0);
        full_run(1, 1'b1);       // R7 restart from hold, R8 mid-run start

        begin_run(2);
        repeat (60) step();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        exp_q.delete();
        step();
        check("R1 reset mid-run strobe", int'(sample_valid_o), 0);
        check("R1 reset mid-run resets", int'(sel_rst_o | pd_rst_o | v_rst_o), 0);
        check("R1 reset mid-run address", int'(mem_addr_o), 0);
        check("R1 reset mid-run data", int'(mem_wdata_o), 0);
        strobes = 0;
        repeat (15) step();
        check("R1 quiet after reset", strobes, 0);

        full_run(3, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule